// File: doc/BRIEF.md
# Board Interrupt Aggregator Register Block

This block sits on a board-level programmable device. It holds a small bank of 32-bit scratch and control registers, and it gathers sixteen level-sensitive external interrupt lines into a single interrupt toward the host processor. The host reaches every register through a plain synchronous register bus. That bus has a byte address, a write strobe, write data, and read data that is registered for one cycle.

The block samples the sixteen lines every clock. Any line whose level differs from the previous sample counts as a change, and its bit in a hidden tracked-level vector takes the new level. When a changed line is enabled in the mask register, the status register is overwritten with a one-hot code for that line. The host interrupt output then copies the line's new level. Status bits are not accumulated. Writing the mask register also replays level changes: the tracked level XOR the status register gives a new level. Each line whose bit differs from the old tracked level has its per-line output driven to the new value, and the tracked level takes the new value.

Top module: `irq_agg_regs`

## Requirements
- R1: After reset, every mapped register reads zero, `host_irq` is low and `line_out` is all zero.
- R2: Ten storage registers keep all 32 written bits, at byte offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4. Read data is registered: it shows the addressed register on the first clock edge after the address is presented.
- R3: The mask register (offset 0xC0) stores the written value ANDed with 0x000FEEFF. The status register (offset 0xD0) does the same. Bits outside that pattern always read zero.
- R4: A read at an unmapped offset returns zero. A write at an unmapped offset changes no register.
- R5: A line counts as changed when its level differs from its level one clock earlier. On a change, the line's tracked-level bit takes the line's new level.
- R6: When a changed line's bit in the mask is 1, the status register becomes a one-hot value with only that line's bit set. On the same edge, `host_irq` takes the line's new level.
- R7: A change on a line whose mask bit is 0 leaves the status register and `host_irq` unchanged.
- R8: When several enabled lines change on the same edge, the lowest-numbered one sets the one-hot status and gives `host_irq` its level.
- R9: On a mask-register write, the new level is the tracked level XOR status bits 15:0. Each `line_out` bit where status is 1 takes the new level, and the other bits hold. The tracked level then becomes the new level, so a second identical write toggles the same outputs back.
- R10: When an enabled line change and a bus write to the status register fall on the same edge, the one-hot interrupt code is stored and the bus data is discarded.
- R11: `line_out` changes only on an edge that carries a mask-register write. It is unaffected by line changes and by other register writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 16 | Level-sensitive external interrupt lines |
| host_irq | output | 1 | Interrupt toward the host processor |
| line_out | output | 16 | Per-line outputs updated by mask writes |

## Verification
The bench aims at the replay arithmetic. Because the XOR is taken against the tracked level, two identical mask writes in a row must toggle the same outputs back. A design that used the raw inputs, or never updated the tracked level, would repeat one value. It drives two enabled lines on the same edge, so that a design picking the highest index shows the wrong one-hot code. It also lands a status write on the same edge as an enabled change, where a design with the wrong priority stores the bus data. It writes all ones to the two interrupt registers to expose a missing bit mask, and it writes at a hole in the map to show an incomplete decode.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned NLINES  = 16;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned NUM_GPR = 10;

  localparam logic [REG_W-1:0]  IRQ_IMPL_MASK = 32'h000F_EEFF;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'hC0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'hD0;

  // byte offset of storage register idx
  function automatic logic [ADDR_W-1:0] gpr_offset(input int idx);
    case (idx)
      0: return 8'h10;
      1: return 8'h14;
      2: return 8'h40;
      3: return 8'h60;
      4: return 8'h80;
      5: return 8'h84;
      6: return 8'h88;
      7: return 8'h90;
      8: return 8'hE0;
      9: return 8'hE4;
      default: return 8'hFF;
    endcase
  endfunction

  // isolate the least significant set bit
  function automatic logic [NLINES-1:0] lowest_onehot(input logic [NLINES-1:0] v);
    return v & (~v + {{(NLINES-1){1'b0}}, 1'b1});
  endfunction

  // level produced by a mask-register write
  function automatic logic [NLINES-1:0] replay_level(input logic [NLINES-1:0] lvl,
                                                     input logic [NLINES-1:0] stat);
    return lvl ^ stat;
  endfunction

  // keep only implemented interrupt register bits
  function automatic logic [REG_W-1:0] impl_bits(input logic [REG_W-1:0] d);
    return d & IRQ_IMPL_MASK;
  endfunction
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned NGPR = NUM_GPR
) (
  input  logic [AW-1:0]   addr,
  output logic [NGPR-1:0] gpr_sel,
  output logic            mask_sel,
  output logic            stat_sel,
  output logic            hit
);
  for (genvar i = 0; i < NGPR; i++) begin : g_sel
    assign gpr_sel[i] = (addr == AW'(gpr_offset(i)));
  end

  assign mask_sel = (addr == AW'(OFS_MASK));
  assign stat_sel = (addr == AW'(OFS_STAT));
  assign hit      = (|gpr_sel) | mask_sel | stat_sel;
endmodule

// File: rtl/irq_agg_gpr.sv
module irq_agg_gpr
  import irq_agg_pkg::*;
#(
  parameter int unsigned W    = REG_W,
  parameter int unsigned NGPR = NUM_GPR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [NGPR-1:0]   sel,
  input  logic [W-1:0]      wdata,
  output logic [NGPR*W-1:0] regs_flat
);
  for (genvar i = 0; i < NGPR; i++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)            q <= '0;
      else if (we && sel[i]) q <= wdata;
    end
    assign regs_flat[i*W +: W] = q;
  end
endmodule

// File: rtl/irq_agg_core.sv
module irq_agg_core
  import irq_agg_pkg::*;
#(
  parameter int unsigned W = REG_W,
  parameter int unsigned N = NLINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic         mask_we,
  input  logic         stat_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] stat_q,
  output logic         host_irq,
  output logic [N-1:0] line_out,
  output logic         ev_any,
  output logic         win_level
);
  localparam int unsigned PAD = W - N;

  logic [N-1:0] in_prev;
  logic [N-1:0] level;
  logic [N-1:0] chg;
  logic [N-1:0] ev;
  logic [N-1:0] win;
  logic [N-1:0] stat_lo;
  logic [N-1:0] repl;
  logic [N-1:0] base;
  logic [N-1:0] level_n;

  assign chg       = irq_in ^ in_prev;
  assign ev        = chg & mask_q[N-1:0];
  assign win       = lowest_onehot(ev);
  assign ev_any    = |ev;
  assign win_level = |(win & irq_in);
  assign stat_lo   = stat_q[N-1:0];
  assign repl      = replay_level(level, stat_lo);
  assign base      = mask_we ? repl : level;
  // a line change on the same edge overrides the replayed bit
  assign level_n   = (base & ~chg) | (irq_in & chg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_prev  <= '0;
      level    <= '0;
      mask_q   <= '0;
      stat_q   <= '0;
      host_irq <= 1'b0;
      line_out <= '0;
    end else begin
      in_prev <= irq_in;
      level   <= level_n;
      if (mask_we) begin
        mask_q   <= impl_bits(wdata);
        line_out <= (line_out & ~stat_lo) | (repl & stat_lo);
      end
      if (ev_any) begin
        stat_q   <= {{PAD{1'b0}}, win};
        host_irq <= win_level;
      end else if (stat_we) begin
        stat_q <= impl_bits(wdata);
      end
    end
  end
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned W    = REG_W,
  parameter int unsigned N    = NLINES,
  parameter int unsigned NGPR = NUM_GPR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [N-1:0]  irq_in,
  output logic          host_irq,
  output logic [N-1:0]  line_out
);
  logic [NGPR-1:0]   gpr_sel;
  logic              mask_sel;
  logic              stat_sel;
  logic              hit;
  logic [NGPR*W-1:0] gpr_flat;
  logic [W-1:0]      mask_q;
  logic [W-1:0]      stat_q;
  logic              mask_wr;
  logic              stat_wr;
  logic              ev_any;
  logic              win_level;
  logic [W-1:0]      rd_mux;

  assign mask_wr = bus_we & mask_sel;
  assign stat_wr = bus_we & stat_sel;

  irq_agg_decode #(.AW(AW), .NGPR(NGPR)) u_dec (
    .addr(bus_addr), .gpr_sel(gpr_sel), .mask_sel(mask_sel),
    .stat_sel(stat_sel), .hit(hit)
  );

  irq_agg_gpr #(.W(W), .NGPR(NGPR)) u_gpr (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .sel(gpr_sel),
    .wdata(bus_wdata), .regs_flat(gpr_flat)
  );

  irq_agg_core #(.W(W), .N(N)) u_core (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .mask_we(mask_wr), .stat_we(stat_wr), .wdata(bus_wdata),
    .mask_q(mask_q), .stat_q(stat_q), .host_irq(host_irq),
    .line_out(line_out), .ev_any(ev_any), .win_level(win_level)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NGPR; i++) begin
      if (gpr_sel[i]) rd_mux = gpr_flat[i*W +: W];
    end
    if (mask_sel) rd_mux = mask_q;
    if (stat_sel) rd_mux = stat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned N  = 16,
  parameter int unsigned GW = 320
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic          hit,
  input logic          mask_wr,
  input logic          ev_any,
  input logic          win_level,
  input logic          host_irq,
  input logic [W-1:0]  stat_q,
  input logic [W-1:0]  bus_rdata,
  input logic [N-1:0]  line_out,
  input logic [GW-1:0] gpr_flat
);
  p_unmapped_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> bus_rdata == '0);

  p_unmapped_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit) |=> $stable(gpr_flat));

  p_status_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any |=> $onehot(stat_q));

  p_host_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any |=> host_irq == $past(win_level));

  p_host_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_any |=> $stable(host_irq));

  p_line_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(line_out));
endmodule

bind irq_agg_regs irq_agg_chk #(.W(W), .N(N), .GW(NGPR*W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .hit(hit), .mask_wr(mask_wr),
  .ev_any(ev_any), .win_level(win_level), .host_irq(host_irq),
  .stat_q(stat_q), .bus_rdata(bus_rdata), .line_out(line_out),
  .gpr_flat(gpr_flat)
);

// File: tb/irq_agg_regs_tb.sv
module irq_agg_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_in = '0;
  logic        host_irq;
  logic [15:0] line_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  irq_agg_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .host_irq(host_irq), .line_out(line_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ofs(input int i);
    logic [7:0] t [10] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80,
                           8'h84, 8'h88, 8'h90, 8'hE0, 8'hE4};
    return t[i];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; irq_in = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic drive(input logic [15:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 10; i++) begin
      rd(ofs(i), rv); check("R1 gpr reset", rv, 32'h0);
    end
    rd(8'hC0, rv); check("R1 mask reset", rv, 32'h0);
    rd(8'hD0, rv); check("R1 status reset", rv, 32'h0);
    check("R1 host_irq reset", {31'b0, host_irq}, 32'h0);
    check("R1 line_out reset", {16'b0, line_out}, 32'h0);
  endtask

  task automatic t_storage();
    for (int i = 0; i < 10; i++) wr(ofs(i), 32'hA5C3_0000 ^ (32'h1111_1111 * (i + 1)));
    for (int i = 0; i < 10; i++) begin
      rd(ofs(i), rv);
      check("R2 storage readback", rv, 32'hA5C3_0000 ^ (32'h1111_1111 * (i + 1)));
    end
  endtask

  task automatic t_implbits();
    wr(8'hC0, 32'hFFFF_FFFF); rd(8'hC0, rv); check("R3 mask bits", rv, 32'h000F_EEFF);
    wr(8'hD0, 32'hFFFF_FFFF); rd(8'hD0, rv); check("R3 status bits", rv, 32'h000F_EEFF);
    wr(8'hC0, 32'h0); wr(8'hD0, 32'h0);
  endtask

  task automatic t_unmapped();
    wr(8'h20, 32'hDEAD_BEEF); rd(8'h20, rv); check("R4 unmapped read", rv, 32'h0);
    wr(8'hC4, 32'hFFFF_FFFF);
    rd(8'h10, rv); check("R4 neighbour kept", rv, 32'hA5C3_0000 ^ 32'h1111_1111);
    rd(8'hC0, rv); check("R4 mask kept", rv, 32'h0);
  endtask

  task automatic t_enabled_disabled();
    do_reset();
    wr(8'hC0, 32'h0000_0023);           // lines 0,1,5 enabled
    drive(16'h0020);
    rd(8'hD0, rv); check("R6 one-hot status", rv, 32'h0000_0020);
    check("R6 host high", {31'b0, host_irq}, 32'h1);
    drive(16'h0000);
    check("R6 host follows low", {31'b0, host_irq}, 32'h0);
    drive(16'h0008);                    // line 3 disabled
    rd(8'hD0, rv); check("R7 status unchanged", rv, 32'h0000_0020);
    check("R7 host unchanged", {31'b0, host_irq}, 32'h0);
    drive(16'h0022 | 16'h0008);         // lines 1 and 5 rise together
    rd(8'hD0, rv); check("R8 lowest wins", rv, 32'h0000_0002);
    check("R8 host level", {31'b0, host_irq}, 32'h1);
  endtask

  task automatic t_replay();
    do_reset();
    wr(8'hC0, 32'h0000_0021);           // lines 0,5
    drive(16'h0020);                    // tracked level 0x0020, status 0x20
    check("R11 line_out idle after change", {16'b0, line_out}, 32'h0);
    wr(8'hD0, 32'h0000_0021);
    wr(8'hC0, 32'h0000_0021);           // new = 0x20^0x21 = 0x01
    check("R5 R9 first replay", {16'b0, line_out}, 32'h0000_0001);
    wr(8'hC0, 32'h0000_0021);           // new = 0x01^0x21 = 0x20
    check("R9 second replay", {16'b0, line_out}, 32'h0000_0020);
    drive(16'h0029);                    // line 0 enabled rise, line 3 disabled
    wr(8'h10, 32'h1234_5678);
    check("R11 line_out held", {16'b0, line_out}, 32'h0000_0020);
  endtask

  task automatic t_collide();
    do_reset();
    wr(8'hC0, 32'h0000_0001);
    @(negedge clk);
    irq_in = 16'h0001; bus_addr = 8'hD0; bus_we = 1'b1; bus_wdata = 32'h0000_0F0F;
    @(negedge clk);
    bus_we = 1'b0;
    rd(8'hD0, rv); check("R10 event beats write", rv, 32'h0000_0001);
    check("R10 host level", {31'b0, host_irq}, 32'h1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_storage();
    t_implbits();
    t_unmapped();
    t_enabled_disabled();
    t_replay();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule